// File: doc/BRIEF.md
# Clocked Serial Byte Shifter

This block runs a serial channel in synchronous mode. It drives a shift clock and a transmit line, and it samples a receive line. It moves one byte at a time in each direction. A one-cycle baud tick from an external rate divider paces the channel, and each bit takes two ticks. The first tick of a bit is the shift phase: the shift clock goes to its active level and the transmit line takes the next bit. The second tick is the latch phase: the shift clock returns to its idle level and the receive line is sampled. Bits travel least significant first.

Software-side logic writes a byte with a one-cycle strobe into a single holding slot. The slot moves into the shifter when the channel starts, or when the current byte ends. The block then pulses a flag to say the slot is free again. If a new byte is waiting when a byte ends, the first bit of the new byte goes out on the very next tick, so no idle period appears between bytes. If the slot is empty at that point, the clock rests at its idle level and the transmit line keeps its last bit.

After the eighth latch, the assembled receive byte appears on a parallel output, together with a one-cycle done strobe.

Top module: `ssx_engine`

## Requirements
- R1: When no byte is held in the slot, baud ticks leave `sclk` at its idle level (1 with default parameters) and leave `txd` unchanged. Out of reset, `txd` is 1.
- R2: `wr_en` loads `wr_byte` only while `slot_free` is 1, and `slot_free` then goes to 0. A write while `slot_free` is 0 is ignored and does not replace the held byte.
- R3: With the channel idle and a byte held, the next tick does three things. It moves the byte into the shifter, drives `sclk` to the active level (0) and puts bit 0 on `txd`. In the cycle after that tick edge, `slot_taken` is 1 for exactly one cycle and `slot_free` reads 1.
- R4: Each shift-phase tick drives `sclk` to 0 and drives the next bit onto `txd`. The bits go out in the order bit 0, bit 1, up to bit 7.
- R5: Each latch-phase tick returns `sclk` to 1 and samples `rxd`, with `txd` unchanged.
- R6: In the cycle after the eighth latch tick, `rx_done` is 1 for exactly one cycle. `rx_byte` then holds the received byte, with the first sampled bit in bit 0 and the eighth in bit 7.
- R7: If a byte is held when the eighth latch of the current byte completes, the next tick is a shift tick that drives bit 0 of the held byte. No idle tick comes in between.
- R8: If the slot is empty when a byte ends, the next tick leaves `sclk` at 1 and `txd` at bit 7 of the finished byte, and the channel goes idle.
- R9: `sclk` and `txd` change only on a clock edge where `baud_tick` is 1 or `rst` is 1.
- R10: A synchronous reset makes `sclk` 1, `txd` 1, `slot_free` 1 and `rx_byte` 0. A byte sent afterwards starts again from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle pacing tick; each bit takes two ticks |
| wr_en | input | 1 | Write strobe for the holding slot |
| wr_byte | input | 8 | Byte to transmit |
| slot_free | output | 1 | Holding slot can accept a byte |
| slot_taken | output | 1 | One-cycle pulse when the slot moves into the shifter |
| sclk | output | 1 | Outgoing shift clock |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_byte | output | 8 | Last fully received byte |
| rx_done | output | 1 | One-cycle strobe when `rx_byte` is updated |

## Verification
The transfer is driven with asymmetric byte pairs (0xA5 out while 0x3C comes in, and 0x01 against 0x80), so the tests can tell a reversed bit order from a correct one. They also expose an off-by-one shift or a transmit/receive swap. A two-byte back-to-back run shows whether a gap tick is inserted between bytes. Runs that finish with an empty slot, and a stream of ticks with no byte written, show whether the clock keeps toggling when idle. A write into a full slot and a reset in the middle of a byte test the loading rules and whether the bit counter is cleared.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_SHIFTED = 2'd1,
      ST_LATCHED = 2'd2
   } ssx_state_e;
endpackage

// File: rtl/ssx_slot.sv
module ssx_slot #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] held
);
   always_ff @(posedge clk) begin
      if (rst) begin
         full <= 1'b0;
         held <= '0;
      end else if (take) begin
         full <= 1'b0;
      end else if (wr_en && !full) begin
         full <= 1'b1;
         held <= wr_byte;
      end
   end
endmodule

// File: rtl/ssx_seq.sv
module ssx_seq
   import ssx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic baud_tick,
   input  logic slot_full,
   output logic do_load,
   output logic do_shift,
   output logic do_latch,
   output logic byte_end,
   output logic clk_active
);
   localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   ssx_state_e       state;
   logic [CNT_W-1:0] bit_idx;
   logic             at_last;
   logic             wrap_tick;

   assign at_last   = (bit_idx == LAST_BIT);
   assign wrap_tick = baud_tick && (state == ST_LATCHED) && at_last;
   assign do_load   = baud_tick && slot_full &&
                      ((state == ST_IDLE) || ((state == ST_LATCHED) && at_last));
   assign do_shift  = baud_tick && (state == ST_LATCHED) && !at_last;
   assign do_latch  = baud_tick && (state == ST_SHIFTED);
   assign byte_end  = do_latch && at_last;

   always_ff @(posedge clk) begin
      if (rst) begin
         state      <= ST_IDLE;
         bit_idx    <= '0;
         clk_active <= 1'b0;
      end else if (do_load) begin
         state      <= ST_SHIFTED;
         bit_idx    <= '0;
         clk_active <= 1'b1;
      end else if (do_shift) begin
         state      <= ST_SHIFTED;
         bit_idx    <= bit_idx + 1'b1;
         clk_active <= 1'b1;
      end else if (do_latch) begin
         state      <= ST_LATCHED;
         clk_active <= 1'b0;
      end else if (wrap_tick) begin
         state      <= ST_IDLE;
      end
   end
endmodule

// File: rtl/ssx_datapath.sv
module ssx_datapath #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              do_load,
   input  logic              do_shift,
   input  logic              do_latch,
   input  logic              byte_end,
   input  logic [DATA_W-1:0] load_byte,
   input  logic              rxd,
   output logic              txd,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_done
);
   logic [DATA_W-1:0] tx_sh;
   logic [DATA_W-1:0] rx_sh;
   logic [DATA_W-1:0] rx_next;

   assign rx_next = {rxd, rx_sh[DATA_W-1:1]};

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_sh <= '0;
         txd   <= 1'b1;
      end else if (do_load) begin
         tx_sh <= load_byte;
         txd   <= load_byte[0];
      end else if (do_shift) begin
         tx_sh <= tx_sh >> 1;
         txd   <= tx_sh[1];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rx_sh   <= '0;
         rx_byte <= '0;
         rx_done <= 1'b0;
      end else begin
         rx_done <= byte_end;
         if (do_latch) rx_sh <= rx_next;
         if (byte_end) rx_byte <= rx_next;
      end
   end
endmodule

// File: rtl/ssx_engine.sv
module ssx_engine #(
   parameter int   DATA_W    = 8,
   parameter logic SCLK_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              baud_tick,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_byte,
   output logic              slot_free,
   output logic              slot_taken,
   output logic              sclk,
   output logic              txd,
   input  logic              rxd,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_done
);
   if (DATA_W < 2) begin : g_bad_width
      $error("ssx_engine: DATA_W must be at least 2");
   end

   logic              slot_full;
   logic [DATA_W-1:0] held;
   logic              do_load, do_shift, do_latch, byte_end, clk_active;

   ssx_slot #(.DATA_W(DATA_W)) u_slot (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte),
      .take(do_load), .full(slot_full), .held(held)
   );

   ssx_seq #(.DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst(rst), .baud_tick(baud_tick), .slot_full(slot_full),
      .do_load(do_load), .do_shift(do_shift), .do_latch(do_latch),
      .byte_end(byte_end), .clk_active(clk_active)
   );

   ssx_datapath #(.DATA_W(DATA_W)) u_dp (
      .clk(clk), .rst(rst), .do_load(do_load), .do_shift(do_shift),
      .do_latch(do_latch), .byte_end(byte_end), .load_byte(held),
      .rxd(rxd), .txd(txd), .rx_byte(rx_byte), .rx_done(rx_done)
   );

   always_ff @(posedge clk) begin
      if (rst) slot_taken <= 1'b0;
      else     slot_taken <= do_load;
   end

   assign slot_free = !slot_full;

   if (SCLK_IDLE) begin : g_idle_high
      assign sclk = !clk_active;
   end else begin : g_idle_low
      assign sclk = clk_active;
   end
endmodule

// File: rtl/ssx_engine_chk.sv
module ssx_engine_chk #(
   parameter logic SCLK_IDLE = 1'b1
) (
   input logic clk,
   input logic rst,
   input logic baud_tick,
   input logic sclk,
   input logic txd,
   input logic slot_free,
   input logic slot_taken,
   input logic rx_done
);
   // R9: serial outputs move only on a tick or reset edge
   a_r9_quiet_between_ticks: assert property (@(posedge clk) disable iff (rst)
      (!$past(baud_tick) && !$past(rst)) |-> ($stable(sclk) && $stable(txd)));

   // R5: a latch phase leaves the transmit line alone
   a_r5_latch_holds_txd: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && (sclk == SCLK_IDLE) && (sclk != $past(sclk))) |-> $stable(txd));

   // R6: done strobe lasts one cycle and coincides with a latch edge
   a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
      rx_done |=> !rx_done);
   a_r6_done_on_latch: assert property (@(posedge clk) disable iff (rst)
      rx_done |-> (sclk == SCLK_IDLE && $past(sclk) != SCLK_IDLE));

   // R3: slot hand-off pulse is single and leaves the slot free
   a_r3_taken_one_cycle: assert property (@(posedge clk) disable iff (rst)
      slot_taken |=> !slot_taken);
   a_r3_taken_frees_slot: assert property (@(posedge clk) disable iff (rst)
      slot_taken |-> slot_free);
endmodule

bind ssx_engine ssx_engine_chk #(.SCLK_IDLE(SCLK_IDLE)) u_chk (
   .clk(clk), .rst(rst), .baud_tick(baud_tick), .sclk(sclk), .txd(txd),
   .slot_free(slot_free), .slot_taken(slot_taken), .rx_done(rx_done)
);

// File: tb/ssx_engine_bench.sv
module ssx_engine_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       baud_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_byte = 8'h00;
   logic       rxd = 1'b0;
   logic       slot_free, slot_taken, sclk, txd, rx_done;
   logic [7:0] rx_byte;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ssx_engine u_ssx_engine (
      .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en),
      .wr_byte(wr_byte), .slot_free(slot_free), .slot_taken(slot_taken),
      .sclk(sclk), .txd(txd), .rxd(rxd), .rx_byte(rx_byte), .rx_done(rx_done)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk) baud_tick = 1'b1;
      @(negedge clk) baud_tick = 1'b0;
   endtask

   task automatic write(input logic [7:0] b);
      @(negedge clk) begin wr_en = 1'b1; wr_byte = b; end
      @(negedge clk) wr_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk) rst = 1'b1;
      @(negedge clk) rst = 1'b0;
   endtask

   // one full byte, beginning with the tick that loads it
   task automatic xfer(input logic [7:0] b, input logic [7:0] r,
                       input bit nxt_v, input logic [7:0] nxt, input string start_req);
      tick();
      check({start_req, " sclk active"}, sclk, 0);
      check({start_req, " bit0"}, txd, b[0]);
      check("R3 slot_taken", slot_taken, 1);
      check("R3 slot_free", slot_free, 1);
      @(negedge clk);
      check("R3 slot_taken one cycle", slot_taken, 0);
      if (nxt_v) write(nxt);
      for (int i = 0; i < 8; i++) begin
         if (i > 0) begin
            tick();
            check("R4 shift sclk", sclk, 0);
            check("R4 shift bit", txd, b[i]);
         end
         rxd = r[i];
         tick();
         check("R5 latch sclk", sclk, 1);
         check("R5 latch txd", txd, b[i]);
         if (i == 7) begin
            check("R6 rx_done", rx_done, 1);
            check("R6 rx_byte", rx_byte, r);
            @(negedge clk);
            check("R6 rx_done one cycle", rx_done, 0);
         end
         @(negedge clk);
      end
   endtask

   task automatic t_reset_state();
      check("R10 sclk", sclk, 1);
      check("R10 txd", txd, 1);
      check("R10 slot_free", slot_free, 1);
      check("R10 rx_byte", rx_byte, 0);
      check("R1 rx_done idle", rx_done, 0);
   endtask

   task automatic t_idle_ticks();
      for (int i = 0; i < 4; i++) begin
         tick();
         check("R1 idle sclk", sclk, 1);
         check("R1 idle txd", txd, 1);
      end
   endtask

   task automatic t_single();
      write(8'hA5);
      check("R2 slot taken by write", slot_free, 0);
      xfer(8'hA5, 8'h3C, 1'b0, 8'h00, "R3");
      tick();
      check("R8 sclk rests", sclk, 1);
      check("R8 txd holds bit7", txd, 1);
      tick();
      check("R1 after byte sclk", sclk, 1);
      check("R1 after byte txd", txd, 1);
   endtask

   task automatic t_back_to_back();
      write(8'h01);
      xfer(8'h01, 8'h80, 1'b1, 8'hC6, "R3");
      xfer(8'hC6, 8'h5A, 1'b0, 8'h00, "R7");
      tick();
      check("R8 second end sclk", sclk, 1);
      check("R8 second end txd", txd, 1);
   endtask

   task automatic t_write_full();
      write(8'h0F);
      write(8'hF0);
      check("R2 still full", slot_free, 0);
      xfer(8'h0F, 8'hE1, 1'b0, 8'h00, "R2");
      tick();
      check("R8 end txd", txd, 0);
   endtask

   task automatic t_mid_reset();
      write(8'hFF);
      tick();
      tick();
      rxd = 1'b1;
      tick();
      do_reset();
      check("R10 sclk after reset", sclk, 1);
      check("R10 txd after reset", txd, 1);
      check("R10 slot_free after reset", slot_free, 1);
      write(8'h42);
      xfer(8'h42, 8'h99, 1'b0, 8'h00, "R10");
      tick();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset_state();
      t_idle_ticks();
      t_single();
      t_back_to_back();
      t_write_full();
      t_mid_reset();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule